// File: doc/BRIEF.md
# Peripheral Clock Gate Control Register

This block holds the 16-bit clock control word for one peripheral and drives the clock enable of that peripheral. Software writes the word to ask for the module to be switched off. The module clock is stopped only once the peripheral signals through its idle input that it has finished its current work. A debug break input can also stop the clock, but only when a per-module suspend enable bit in the word is set.

The clock enable output is registered. A read-only status bit in the word shows whether the module clock is actually off. It follows the registered enable one cycle later, so software can poll it to confirm that gating has taken effect. Three further bits act as plain read/write storage. The other bits are reserved and read as zero.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset the read word is 0x0000 and clk_en_o is 1.
- R2: Bit 0 (disable request) is read/write. Writing 1 sets the request and writing 0 clears it.
- R3: While the clock is running and mod_idle_i is 0, clk_en_o stays 1 on the next cycle, whatever the request or the break.
- R4: If clk_en_o is 1, mod_idle_i is 1 and the stored disable request is 1 in some cycle, then clk_en_o is 0 in the next cycle.
- R5: Bit 1 (status) reads as the inverse of clk_en_o from the previous cycle. Writes to bit 1 are ignored.
- R6: Bit 3 (suspend enable) is read/write. When it is 1 and dbg_halt_i is 1, an idle module is gated on the next cycle. When it is 0, dbg_halt_i has no effect on clk_en_o.
- R7: While gated, if the disable request is 0 and no suspend is active (bit 3 is 0 or dbg_halt_i is 0), clk_en_o returns to 1 on the next cycle whatever mod_idle_i is. The status bit clears one cycle after that.
- R8: Bits 4, 5 and 6 are read/write storage, reset to 0, and have no effect on clk_en_o.
- R9: Bits 2 and 7 to 15 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the full word |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Current word, including the live status bit |
| dbg_halt_i | input | 1 | High while a debug break is active |
| mod_idle_i | input | 1 | High when the peripheral is idle |
| clk_en_o | output | 1 | Registered clock enable for the peripheral |

## Verification
A register write can land in the same cycle as a gating decision, so the request bit changes at the edge where the enable is also being updated. The gating decision must use the value held before the write. The bench provokes this case with directed writes while the module is idle and the clock is running. Random writes, breaks and idle toggles also make it happen often. Each cycle is judged against a bench model that applies the gating rule to the pre-write word and only then stores the new word.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned REQ_BIT   = 0;
  localparam int unsigned STAT_BIT  = 1;
  localparam int unsigned SPEN_BIT  = 3;
  localparam int unsigned SPARE_LSB = 4;
  localparam int unsigned SPARE_W   = 3;

  function automatic logic [WORD_W-1:0] rw_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[REQ_BIT]  = 1'b1;
    m[SPEN_BIT] = 1'b1;
    for (int i = 0; i < SPARE_W; i++) m[SPARE_LSB+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cgc_regs.sv
module cgc_regs
  import cgc_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctl_o
);
  localparam logic [W-1:0] MASK = W'(rw_mask());

  logic [W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctl_q <= '0;
    else if (wr_en_i) ctl_q <= wdata_i & MASK;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/cgc_gate.sv
module cgc_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dis_req_i,
  input  logic spen_i,
  input  logic halt_i,
  input  logic idle_i,
  output logic clk_en_o,
  output logic stat_o
);
  logic stop_want;
  logic en_d, en_q, stat_q;

  assign stop_want = dis_req_i | (spen_i & halt_i);

  // gating waits for idle; re-enable is immediate
  always_comb begin
    if (en_q) en_d = ~(stop_want & idle_i);
    else      en_d = ~stop_want;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      stat_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      stat_q <= ~en_q;
    end
  end

  assign clk_en_o = en_q;
  assign stat_o   = stat_q;
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import cgc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              dbg_halt_i,
  input  logic              mod_idle_i,
  output logic              clk_en_o
);
  logic [WORD_W-1:0] ctl;
  logic              stat;

  cgc_regs #(.W(WORD_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .ctl_o   (ctl)
  );

  cgc_gate i_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dis_req_i (ctl[REQ_BIT]),
    .spen_i    (ctl[SPEN_BIT]),
    .halt_i    (dbg_halt_i),
    .idle_i    (mod_idle_i),
    .clk_en_o  (clk_en_o),
    .stat_o    (stat)
  );

  always_comb begin
    rdata_o           = ctl;
    rdata_o[STAT_BIT] = stat;
  end
endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] rdata_o,
  input logic        dbg_halt_i,
  input logic        mod_idle_i,
  input logic        clk_en_o
);
  p_idle_guard_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && !mod_idle_i) |=> clk_en_o);

  p_gate_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && mod_idle_i && rdata_o[0]) |=> !clk_en_o);

  p_stat_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rdata_o[1] == !$past(clk_en_o)));

  p_halt_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdata_o[3] && !rdata_o[0]) |=> clk_en_o);

  p_reenable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_o && !rdata_o[0] && !(rdata_o[3] && dbg_halt_i)) |=> clk_en_o);

  p_resv_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[2] == 1'b0) && (rdata_o[15:7] == 9'd0));

  logic unused_wr;
  assign unused_wr = wr_en_i;
endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rdata_o    (rdata_o),
  .dbg_halt_i (dbg_halt_i),
  .mod_idle_i (mod_idle_i),
  .clk_en_o   (clk_en_o)
);

// File: tb/test_clk_gate_ctrl.sv
module test_clk_gate_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        dbg_halt_i = 1'b0;
  logic        mod_idle_i = 1'b0;
  logic        clk_en_o;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic       m_req = 0, m_sp = 0, m_en = 1, m_stat = 0;
  logic [2:0] m_spare = 0;

  always #4 clk_i = ~clk_i;

  clk_gate_ctrl i_clk_gate_ctrl (.*);

  function automatic logic [15:0] exp_word(logic req, logic stat, logic sp, logic [2:0] spare);
    return {9'd0, spare, sp, 1'b0, stat, req};
  endfunction

  function automatic logic next_en(logic en, logic req, logic sp, logic halt, logic idle);
    logic stop;
    stop = req | (sp & halt);
    return en ? !(stop & idle) : !stop;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one cycle: drive at negedge, update model, compare at next negedge
  task automatic step(string tag, logic wr, logic [15:0] wd, logic halt, logic idle);
    logic en_n;
    wr_en_i = wr; wdata_i = wd; dbg_halt_i = halt; mod_idle_i = idle;
    en_n   = next_en(m_en, m_req, m_sp, halt, idle);
    m_stat = !m_en;
    m_en   = en_n;
    if (wr) begin
      m_req = wd[0]; m_sp = wd[3]; m_spare = wd[6:4];
    end
    @(negedge clk_i);
    chk({tag, " word"}, rdata_o, exp_word(m_req, m_stat, m_sp, m_spare));
    chk({tag, " clk_en"}, {15'd0, clk_en_o}, {15'd0, m_en});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    chk("R1 reset word", rdata_o, 16'h0000);
    chk("R1 reset clk_en", {15'd0, clk_en_o}, 16'h0001);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5/R9: status and reserved bits not writable
    step("R5 R9 write ones to ro bits", 1, 16'hFF86, 0, 1);
    step("R9 reserved stay 0", 0, 0, 0, 1);
    // R8: spare bits stored, no gating
    step("R8 spare write", 1, 16'h0070, 1, 1);
    step("R8 spare no gating", 0, 0, 1, 1);
    // R2/R3: request while busy
    step("R2 request set", 1, 16'h0001, 0, 0);
    for (int i = 0; i < 4; i++) step("R3 busy holds clock", 0, 0, 0, 0);
    // R4/R5
    step("R4 idle gates", 0, 0, 0, 1);
    step("R5 status set", 0, 0, 0, 0);
    // R7: clear request with module busy
    step("R2 R7 request cleared", 1, 16'h0000, 0, 0);
    step("R7 status clears", 0, 0, 0, 0);
    // R6: suspend enable
    step("R6 halt masked", 1, 16'h0000, 1, 1);
    step("R6 halt masked hold", 0, 0, 1, 1);
    step("R6 spen set", 1, 16'h0008, 1, 0);
    step("R6 halt busy", 0, 0, 1, 0);
    step("R6 halt idle gates", 0, 0, 1, 1);
    step("R6 stays gated", 0, 0, 1, 0);
    step("R7 halt drop reenables", 0, 0, 0, 0);
    step("R7 status clears", 0, 0, 0, 1);
    // same-cycle write and gating decision
    step("R4 arm", 1, 16'h0001, 0, 1);
    step("R4 write during gate", 1, 16'h0000, 0, 1);
    step("R7 after clear", 0, 0, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [15:0] wd;
      wr = ($urandom % 4) == 0;
      wd = 16'($urandom);
      step("RAND R2 R3 R4 R5 R6 R7 R8 R9", wr, wd, ($urandom % 3) == 0, ($urandom % 2) == 0);
    end
    finish_run();
  end
endmodule